// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Checker

This block sits at the decode stage of an in-order core that has two execution pipes of unequal capability. The primary pipe runs any instruction class. The secondary pipe runs only a restricted set of classes. Each cycle the block looks at the next two decoded instructions in program order. The older one is slot A and the younger one is slot B. The block decides whether both issue together, only the older one issues, or nothing issues.

Pairing is static and never reorders. When both instructions issue, the older one is steered to the primary pipe and the younger one to the secondary pipe. The block also declines to pair in these cases:
- the younger instruction depends on a register that the older one writes;
- the older instruction is a branch;
- both instructions would need the single data-cache port.

The decision is registered. The issue, steer and consumed-count outputs appear one clock after the instructions are presented, and the fetch queue uses the consumed count to advance.

Top module: `pair_issue`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, prim_valid_o, sec_valid_o, consumed_o, prim_class_o and sec_class_o are all zero.
- R2: Class codes are 0 load, 1 store, 2 simple ALU, 3 branch, 4 cache-op, 5 vector store, 6 complex ALU, 7 multiply/divide and 8 vector arithmetic. Codes 9 to 15 are illegal. The younger instruction may pair only if its class is 0 to 5; otherwise only the older instruction issues.
- R3: Outputs follow the inputs by exactly one clock edge. prim_class_o carries the older instruction's class whenever prim_valid_o is high, whatever that class is. sec_class_o carries the younger instruction's class whenever sec_valid_o is high. sec_valid_o is never high without prim_valid_o.
- R4: If the older instruction is a branch (class 3), the younger instruction is not issued.
- R5: Classes 0, 1, 4 and 5 use the data-cache port. Two such instructions are never issued together.
- R6: If the older instruction writes register a_dst_i (a_we_i=1), the younger one is not issued when either of its enabled sources names that register (b_rd_en_i bit 0 for b_src0_i, bit 1 for b_src1_i). A source whose enable bit is clear creates no dependency.
- R7: If both instructions write (a_we_i and b_we_i high) and their destinations are equal, the younger one is not issued.
- R8: If b_valid_i is low, the older instruction issues alone. If a_valid_i is low, nothing issues, even when b_valid_i is high.
- R9: When stall_i is high, nothing issues.
- R10: consumed_o equals the number of instructions issued in that cycle: 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Blocks all issue this cycle |
| a_valid_i | input | 1 | Older slot holds an instruction |
| a_class_i | input | 4 | Older instruction class |
| a_we_i | input | 1 | Older instruction writes a register |
| a_dst_i | input | RW | Older destination register |
| b_valid_i | input | 1 | Younger slot holds an instruction |
| b_class_i | input | 4 | Younger instruction class |
| b_we_i | input | 1 | Younger instruction writes a register |
| b_dst_i | input | RW | Younger destination register |
| b_rd_en_i | input | 2 | Younger source-read enables |
| b_src0_i | input | RW | Younger first source register |
| b_src1_i | input | RW | Younger second source register |
| prim_valid_o | output | 1 | Primary pipe receives the older instruction |
| sec_valid_o | output | 1 | Secondary pipe receives the younger instruction |
| prim_class_o | output | 4 | Class steered to the primary pipe |
| sec_class_o | output | 4 | Class steered to the secondary pipe |
| consumed_o | output | 2 | Instructions consumed from the fetch queue |

## Verification
The block holds only one register stage, so any fault in the pairing decision shows up at the ports on the very next clock. Such a fault would appear as one of these:
- a sec_valid_o pulse beside a branch, a second memory operation or a dependent instruction;
- a missing pulse where a legal pair was presented;
- a consumed_o value that disagrees with the two valid flags.

Each stimulus cycle is therefore compared one edge later. Every pairing rule is isolated by a case that differs from a legal pair in a single field.

// File: rtl/pair_issue.sv
module pair_issue #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          a_valid_i,
  input  logic [3:0]    a_class_i,
  input  logic          a_we_i,
  input  logic [RW-1:0] a_dst_i,
  input  logic          b_valid_i,
  input  logic [3:0]    b_class_i,
  input  logic          b_we_i,
  input  logic [RW-1:0] b_dst_i,
  input  logic [1:0]    b_rd_en_i,
  input  logic [RW-1:0] b_src0_i,
  input  logic [RW-1:0] b_src1_i,
  output logic          prim_valid_o,
  output logic          sec_valid_o,
  output logic [3:0]    prim_class_o,
  output logic [3:0]    sec_class_o,
  output logic [1:0]    consumed_o
);
  localparam logic [3:0] K_LD = 4'd0, K_ST = 4'd1, K_ALU = 4'd2, K_BR = 4'd3,
                         K_CO = 4'd4, K_VST = 4'd5;

  function automatic logic sec_capable(input logic [3:0] c);
    return c inside {K_LD, K_ST, K_ALU, K_BR, K_CO, K_VST};
  endfunction

  function automatic logic uses_dport(input logic [3:0] c);
    return c inside {K_LD, K_ST, K_CO, K_VST};
  endfunction

  logic raw_hit, waw_hit, pair_ok, go_a, go_b;

  assign raw_hit = a_we_i && ((b_rd_en_i[0] && b_src0_i == a_dst_i) ||
                              (b_rd_en_i[1] && b_src1_i == a_dst_i));
  assign waw_hit = a_we_i && b_we_i && (b_dst_i == a_dst_i);

  assign pair_ok = b_valid_i && sec_capable(b_class_i) && (a_class_i != K_BR) &&
                   !(uses_dport(a_class_i) && uses_dport(b_class_i)) &&
                   !raw_hit && !waw_hit;

  assign go_a = !stall_i && a_valid_i;
  assign go_b = go_a && pair_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prim_valid_o <= 1'b0;
      sec_valid_o  <= 1'b0;
      prim_class_o <= '0;
      sec_class_o  <= '0;
      consumed_o   <= '0;
    end else begin
      prim_valid_o <= go_a;
      sec_valid_o  <= go_b;
      prim_class_o <= go_a ? a_class_i : '0;
      sec_class_o  <= go_b ? b_class_i : '0;
      consumed_o   <= {1'b0, go_a} + {1'b0, go_b};
    end
  end
endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stall_i,
  input logic       a_valid_i,
  input logic [3:0] a_class_i,
  input logic       prim_valid_o,
  input logic       sec_valid_o,
  input logic [3:0] prim_class_o,
  input logic [3:0] sec_class_o,
  input logic [1:0] consumed_o
);
  a_r3_sec_needs_prim: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid_o |-> prim_valid_o);

  a_r2_sec_whitelist: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid_o |-> (sec_class_o <= 4'd5));

  a_r4_branch_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && a_valid_i && a_class_i == 4'd3) |=> !sec_valid_o);

  a_r5_one_dport: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid_o |-> !((prim_class_o inside {4'd0, 4'd1, 4'd4, 4'd5}) &&
                      (sec_class_o  inside {4'd0, 4'd1, 4'd4, 4'd5})));

  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> !prim_valid_o);

  a_r8_no_older_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid_i |=> (!prim_valid_o && !sec_valid_o));

  a_r10_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({prim_valid_o, sec_valid_o}) == int'(consumed_o));
endmodule

bind pair_issue pair_issue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .a_valid_i(a_valid_i),
  .a_class_i(a_class_i), .prim_valid_o(prim_valid_o), .sec_valid_o(sec_valid_o),
  .prim_class_o(prim_class_o), .sec_class_o(sec_class_o), .consumed_o(consumed_o)
);

// File: tb/pair_issue_tb.sv
module pair_issue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic clk = 0, rst_n = 0, stall_i = 0;
  logic a_valid_i = 0, a_we_i = 0, b_valid_i = 0, b_we_i = 0;
  logic [3:0] a_class_i = 0, b_class_i = 0;
  logic [RW-1:0] a_dst_i = 0, b_dst_i = 0, b_src0_i = 0, b_src1_i = 0;
  logic [1:0] b_rd_en_i = 0;
  logic prim_valid_o, sec_valid_o;
  logic [3:0] prim_class_o, sec_class_o;
  logic [1:0] consumed_o;

  int n_cmp = 0, n_bad = 0;
  logic [11:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_issue #(.RW(RW)) u_dut (.*);

  function automatic logic [11:0] model(
      input logic st, av, input logic [3:0] ac, input logic awe, input logic [RW-1:0] ad,
      input logic bv, input logic [3:0] bc, input logic bwe, input logic [RW-1:0] bd,
      input logic [1:0] ren, input logic [RW-1:0] s0, s1);
    logic pa, pb, memA, memB, dep;
    pa   = !st && av;
    memA = (ac == 0) || (ac == 1) || (ac == 4) || (ac == 5);
    memB = (bc == 0) || (bc == 1) || (bc == 4) || (bc == 5);
    dep  = awe && ((ren[0] && s0 == ad) || (ren[1] && s1 == ad) || (bwe && bd == ad));
    pb   = pa && bv && (bc <= 5) && (ac != 3) && !(memA && memB) && !dep;
    return {pa, pb, pa ? ac : 4'd0, pb ? bc : 4'd0, 2'(pa) + 2'(pb)};
  endfunction

  task automatic drive(input string tag, input logic st, av, input logic [3:0] ac,
      input logic awe, input logic [RW-1:0] ad, input logic bv, input logic [3:0] bc,
      input logic bwe, input logic [RW-1:0] bd, input logic [1:0] ren,
      input logic [RW-1:0] s0, s1);
    @(negedge clk);
    stall_i = st; a_valid_i = av; a_class_i = ac; a_we_i = awe; a_dst_i = ad;
    b_valid_i = bv; b_class_i = bc; b_we_i = bwe; b_dst_i = bd;
    b_rd_en_i = ren; b_src0_i = s0; b_src1_i = s1;
    exp_q.push_back(model(st, av, ac, awe, ad, bv, bc, bwe, bd, ren, s0, s1));
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [11:0] e, g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = {prim_valid_o, sec_valid_o, prim_class_o, sec_class_o, consumed_o};
        n_cmp++;
        if (g !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, g, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    a_valid_i = 1; b_valid_i = 1; a_class_i = 2; b_class_i = 2;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if ({prim_valid_o, sec_valid_o, prim_class_o, sec_class_o, consumed_o} !== 12'd0) begin
      n_bad++;
      $display("FAIL R1: got %b%b expected 00", prim_valid_o, sec_valid_o);
    end
    @(negedge clk);
    rst_n = 1;
    a_valid_i = 0; b_valid_i = 0;
    #1;
    n_cmp++;
    if (prim_valid_o !== 1'b0 || consumed_o !== 2'd0) begin
      n_bad++;
      $display("FAIL R1 first cycle: got %b expected 0", prim_valid_o);
    end

    // R2: every secondary-capable younger class pairs with a non-memory, non-branch older
    for (int c = 0; c < 16; c++)
      drive("R2 younger class sweep", 0, 1, 4'd6, 1, 5'd3, 1, 4'(c), 1, 5'd4, 2'b11, 5'd1, 5'd2);
    // R3: older of any class goes to the primary pipe
    for (int c = 0; c < 16; c++)
      drive("R3 older class steer", 0, 1, 4'(c), 1, 5'd3, 1, 4'd2, 1, 5'd4, 2'b11, 5'd1, 5'd2);
    // R4
    drive("R4 older branch", 0, 1, 4'd3, 0, 5'd0, 1, 4'd2, 1, 5'd9, 2'b00, 5'd0, 5'd0);
    drive("R4 younger branch ok", 0, 1, 4'd2, 1, 5'd8, 1, 4'd3, 0, 5'd0, 2'b01, 5'd1, 5'd0);
    // R5
    drive("R5 load+store", 0, 1, 4'd0, 1, 5'd5, 1, 4'd1, 0, 5'd0, 2'b01, 5'd6, 5'd0);
    drive("R5 cacheop+vstore", 0, 1, 4'd4, 0, 5'd0, 1, 4'd5, 0, 5'd0, 2'b00, 5'd0, 5'd0);
    drive("R5 load+alu ok", 0, 1, 4'd0, 1, 5'd5, 1, 4'd2, 1, 5'd7, 2'b11, 5'd6, 5'd8);
    // R6
    drive("R6 raw src0", 0, 1, 4'd6, 1, 5'd10, 1, 4'd2, 1, 5'd11, 2'b01, 5'd10, 5'd0);
    drive("R6 raw src1", 0, 1, 4'd6, 1, 5'd10, 1, 4'd2, 1, 5'd11, 2'b10, 5'd0, 5'd10);
    drive("R6 src disabled", 0, 1, 4'd6, 1, 5'd10, 1, 4'd2, 1, 5'd11, 2'b00, 5'd10, 5'd10);
    drive("R6 older no write", 0, 1, 4'd6, 0, 5'd10, 1, 4'd2, 1, 5'd11, 2'b11, 5'd10, 5'd10);
    // R7
    drive("R7 waw", 0, 1, 4'd7, 1, 5'd12, 1, 4'd2, 1, 5'd12, 2'b00, 5'd0, 5'd0);
    drive("R7 younger no write", 0, 1, 4'd7, 1, 5'd12, 1, 4'd2, 0, 5'd12, 2'b00, 5'd0, 5'd0);
    // R8
    drive("R8 younger invalid", 0, 1, 4'd8, 0, 5'd0, 0, 4'd2, 0, 5'd0, 2'b00, 5'd0, 5'd0);
    drive("R8 older invalid", 0, 0, 4'd2, 0, 5'd0, 1, 4'd2, 0, 5'd0, 2'b00, 5'd0, 5'd0);
    // R9
    drive("R9 stall", 1, 1, 4'd2, 0, 5'd0, 1, 4'd0, 0, 5'd0, 2'b00, 5'd0, 5'd0);
    drive("R9 release", 0, 1, 4'd2, 0, 5'd0, 1, 4'd0, 0, 5'd0, 2'b00, 5'd0, 5'd0);
    // R10: consumed counts of 2, 1, 0 back to back
    drive("R10 two", 0, 1, 4'd6, 0, 5'd0, 1, 4'd1, 0, 5'd0, 2'b00, 5'd0, 5'd0);
    drive("R10 one", 0, 1, 4'd6, 0, 5'd0, 1, 4'd7, 0, 5'd0, 2'b00, 5'd0, 5'd0);
    drive("R10 zero", 0, 0, 4'd6, 0, 5'd0, 0, 4'd7, 0, 5'd0, 2'b00, 5'd0, 5'd0);
    @(negedge clk);
    a_valid_i = 0; b_valid_i = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule